// File: doc/BRIEF.md
# Serial EEPROM Write-Path Controller

This block is the slave side of a four-wire serial link for a small byte-wide EEPROM. It handles the write path only. It decodes four single-byte instructions: latch-set, latch-clear, page write and status read. For a page write it takes a 16-bit address and then between one and 64 data bytes into a page buffer. When chip select returns high at a clean byte boundary, it starts a timed programming cycle. That cycle copies the buffered bytes into an on-chip RAM that stands in for the cell array.

All serial pins are brought into the system clock domain and sampled there. The system clock must run at least several times faster than the serial clock. Data on `si` is taken on rising `sck` edges, and `so` changes after falling edges, so serial modes 0 and 3 both work. `so_oe` is the pad enable for `so`. A separate read port on the RAM, with one clock of latency, lets the surrounding chip inspect the array. The serial pins are plain level inputs with no flow control. No back-pressure exists: a byte that arrives while the device is programming is dropped, unless it is the status-read instruction.

Top module: `spi_eeprom_wr_ctrl`

## Requirements
- R1: After reset `so_oe` is 0 and a status read returns 0x00.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Opcode 0x05 makes the device return the status byte {6'b0, latch, busy} on `so`, MSB first (latch = bit 1, busy = bit 0). The byte repeats for as long as chip select stays low, and each bit is valid before the rising `sck` edge that follows the falling edge that launched it.
- R3: Opcode 0x02 sent while the latch is clear is ignored. No busy period starts and the array is unchanged.
- R4: A write frame is opcode, address high byte, address low byte, then data, all MSB first. Only address bits [ARRAY_AW-1:0] select the byte; the upper address bits are ignored.
- R5: After each data byte the low PAGE_AW address bits increment and the page bits stay fixed. Loading past the last byte of the page wraps to byte 0 of the same page, and the last byte loaded to a position is the one programmed.
- R6: Programming starts only when chip select rises after at least one complete data byte with no partial byte pending. A frame that ends mid-byte, or with no data byte, is dropped: no busy period starts, the array is unchanged, and the latch keeps its value.
- R7: The busy bit reads 1 from three system clocks after chip select rises on an accepted write until 2^PAGE_AW + PROG_CYCLES clocks later, and then returns to 0.
- R8: While busy, every instruction except 0x05 is ignored. Latch-clear has no effect and a write frame does not change the array.
- R9: The write-enable latch clears by itself when the programming cycle ends.
- R10: `so_oe` stays 0 throughout write, latch-set and latch-clear frames. It rises only after a 0x05 opcode has been received.
- R11: Mode 3 timing (`sck` idle high) gives the same results as mode 0.
- R12: `mem_rd_data` returns the array byte at `mem_rd_addr` one system clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out (0 when not enabled) |
| so_oe | output | 1 | Output enable for the `so` pad |
| mem_rd_addr | input | ARRAY_AW | Array inspection address |
| mem_rd_data | output | 8 | Array byte at `mem_rd_addr`, one clock later |

## Verification
Each serial edge reaches the control logic three system clocks after the pin moves: two synchroniser flops and an edge register. The bench therefore holds every `sck` phase for six clocks. It samples `so` at the end of the low phase, which is after the update that the falling edge triggered. Busy is checked by a status read that starts six clocks after chip select rises, well after the three-clock start delay. Completion is checked by polling status until the ready bit clears. Array contents are read back one clock after the address is driven, sampling on the falling clock edge, and are compared with a bench page-buffer model that applies the wrap and last-write-wins rules.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OP_LATCH_SET = 8'h06;
  localparam logic [7:0] OP_LATCH_CLR = 8'h04;
  localparam logic [7:0] OP_PAGE_WR   = 8'h02;
  localparam logic [7:0] OP_STAT_RD   = 8'h05;

  typedef enum logic [2:0] {
    FR_OPC,
    FR_ADDR,
    FR_DATA,
    FR_STAT,
    FR_SKIP
  } frame_e;

  typedef enum logic [1:0] {
    PG_IDLE,
    PG_COPY,
    PG_WAIT
  } prog_e;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise,
  output logic cs_n_s,
  output logic si_s
);
  logic [STAGES-1:0] sck_q, cs_q, si_q;
  logic sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      si_q  <= '0;
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_q <= {sck_q[STAGES-2:0], sck};
      cs_q  <= {cs_q[STAGES-2:0], cs_n};
      si_q  <= {si_q[STAGES-2:0], si};
      sck_d <= sck_q[STAGES-1];
      cs_d  <= cs_q[STAGES-1];
    end
  end

  assign sck_rise = sck_q[STAGES-1] & ~sck_d;
  assign sck_fall = ~sck_q[STAGES-1] & sck_d;
  assign cs_rise  = cs_q[STAGES-1] & ~cs_d;
  assign cs_n_s   = cs_q[STAGES-1];
  assign si_s     = si_q[STAGES-1];
endmodule

// File: rtl/spi_shift_rx.sv
module spi_shift_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n_s,
  input  logic       sck_rise,
  input  logic       si_s,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic [2:0] bit_cnt
);
  logic [6:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      bit_cnt   <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        sh_q    <= {sh_q[5:0], si_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld  <= 1'b1;
          byte_data <= {sh_q, si_s};
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int PAGE_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [PAGE_AW-1:0] wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [PAGE_AW-1:0] rd_idx,
  output logic [7:0]         rd_data,
  output logic               rd_mark,
  output logic               any_mark
);
  localparam int NBYTES = 1 << PAGE_AW;

  logic [7:0]        data_q [NBYTES];
  logic [NBYTES-1:0] mark_q;

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q <= '0;
    end else if (clr) begin
      mark_q <= '0;
    end else if (wr_en) begin
      mark_q[wr_idx] <= 1'b1;
    end
  end

  assign rd_data  = data_q[rd_idx];
  assign rd_mark  = mark_q[rd_idx];
  assign any_mark = |mark_q;
endmodule

// File: rtl/eeprom_ram.sv
module eeprom_ram #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/spi_eeprom_wr_ctrl.sv
module spi_eeprom_wr_ctrl
  import spi_ee_pkg::*;
#(
  parameter int ARRAY_AW    = 11,
  parameter int PAGE_AW     = 6,
  parameter int PROG_CYCLES = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck,
  input  logic                cs_n,
  input  logic                si,
  output logic                so,
  output logic                so_oe,
  input  logic [ARRAY_AW-1:0] mem_rd_addr,
  output logic [7:0]          mem_rd_data
);
  localparam int PG_W   = ARRAY_AW - PAGE_AW;
  localparam int HI_W   = ARRAY_AW - 8;
  localparam int WCNT_W = $clog2(PROG_CYCLES + 1);

  logic sck_rise, sck_fall, cs_rise, cs_n_s, si_s;
  logic       rx_vld;
  logic [7:0] rx_byte;
  logic [2:0] bit_cnt;

  frame_e             fr_q;
  prog_e              pg_q;
  logic               addr_sel_q;
  logic [HI_W-1:0]    addr_hi_q;
  logic [PG_W-1:0]    page_q;
  logic [PAGE_AW-1:0] ptr_q;
  logic               wel_q;
  logic [PAGE_AW-1:0] cp_idx_q;
  logic [WCNT_W-1:0]  wait_q;
  logic [7:0]         so_sh_q;

  logic               busy, in_data, in_stat, prog_start, buf_clr, buf_wr;
  logic [7:0]         buf_rd_data;
  logic               buf_rd_mark, buf_any;
  logic               mem_we;
  logic [ARRAY_AW-1:0] addr_full;
  logic [7:0]         status;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise),
    .cs_n_s(cs_n_s), .si_s(si_s)
  );

  spi_shift_rx rx_i (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sck_rise(sck_rise),
    .si_s(si_s), .byte_vld(rx_vld), .byte_data(rx_byte), .bit_cnt(bit_cnt)
  );

  assign busy      = (pg_q != PG_IDLE);
  assign in_data   = (fr_q == FR_DATA);
  assign in_stat   = (fr_q == FR_STAT);
  assign status    = {6'b0, wel_q, busy};
  assign addr_full = {addr_hi_q, rx_byte};

  // A write is armed only if the opcode arrives with the latch set and idle
  assign buf_clr = rx_vld && !cs_n_s && (fr_q == FR_OPC) &&
                   (rx_byte == OP_PAGE_WR) && wel_q && !busy;
  assign buf_wr  = rx_vld && !cs_n_s && in_data;

  // Commit only at a byte boundary with at least one byte loaded
  assign prog_start = cs_rise && in_data && buf_any && (bit_cnt == 3'd0) && !busy;

  eeprom_page_buf #(.PAGE_AW(PAGE_AW)) pbuf_i (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr),
    .wr_idx(ptr_q), .wr_data(rx_byte), .rd_idx(cp_idx_q),
    .rd_data(buf_rd_data), .rd_mark(buf_rd_mark), .any_mark(buf_any)
  );

  assign mem_we = (pg_q == PG_COPY) && buf_rd_mark;

  eeprom_ram #(.AW(ARRAY_AW)) ram_i (
    .clk(clk), .we(mem_we), .waddr({page_q, cp_idx_q}), .wdata(buf_rd_data),
    .raddr(mem_rd_addr), .rdata(mem_rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q       <= FR_OPC;
      addr_sel_q <= 1'b0;
      addr_hi_q  <= '0;
      page_q     <= '0;
      ptr_q      <= '0;
      wel_q      <= 1'b0;
      pg_q       <= PG_IDLE;
      cp_idx_q   <= '0;
      wait_q     <= '0;
    end else begin
      if (cs_n_s) begin
        fr_q       <= FR_OPC;
        addr_sel_q <= 1'b0;
      end else if (rx_vld) begin
        unique case (fr_q)
          FR_OPC: begin
            if (busy) begin
              fr_q <= (rx_byte == OP_STAT_RD) ? FR_STAT : FR_SKIP;
            end else begin
              unique case (rx_byte)
                OP_LATCH_SET: begin wel_q <= 1'b1; fr_q <= FR_SKIP; end
                OP_LATCH_CLR: begin wel_q <= 1'b0; fr_q <= FR_SKIP; end
                OP_STAT_RD:   fr_q <= FR_STAT;
                OP_PAGE_WR:   fr_q <= wel_q ? FR_ADDR : FR_SKIP;
                default:      fr_q <= FR_SKIP;
              endcase
            end
          end
          FR_ADDR: begin
            if (!addr_sel_q) begin
              addr_hi_q  <= rx_byte[HI_W-1:0];
              addr_sel_q <= 1'b1;
            end else begin
              page_q <= addr_full[ARRAY_AW-1:PAGE_AW];
              ptr_q  <= addr_full[PAGE_AW-1:0];
              fr_q   <= FR_DATA;
            end
          end
          FR_DATA: ptr_q <= ptr_q + 1'b1;
          default: ;
        endcase
      end

      unique case (pg_q)
        PG_IDLE: begin
          if (prog_start) begin
            pg_q     <= PG_COPY;
            cp_idx_q <= '0;
          end
        end
        PG_COPY: begin
          cp_idx_q <= cp_idx_q + 1'b1;
          if (&cp_idx_q) begin
            pg_q   <= PG_WAIT;
            wait_q <= '0;
          end
        end
        PG_WAIT: begin
          if (wait_q == WCNT_W'(PROG_CYCLES - 1)) begin
            pg_q  <= PG_IDLE;
            wel_q <= 1'b0;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        default: pg_q <= PG_IDLE;
      endcase
    end
  end

  // Status shifter: reload at each byte boundary, shift on the other falls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      so_sh_q <= '0;
    end else if (sck_fall && in_stat && !cs_n_s) begin
      if (bit_cnt == 3'd0) so_sh_q <= status;
      else                 so_sh_q <= {so_sh_q[6:0], 1'b0};
    end
  end

  assign so_oe = in_stat & ~cs_n_s;
  assign so    = so_oe ? so_sh_q[7] : 1'b0;
endmodule

// File: rtl/spi_ee_wr_chk.sv
module spi_ee_wr_chk #(
  parameter int PG_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            wel,
  input logic            mem_we,
  input logic            cs_rise,
  input logic            in_data,
  input logic [PG_W-1:0] page
);
  // R9: latch is clear once the programming cycle ends
  a_r9_latch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  // R3: a programming cycle only begins with the latch set
  a_r3_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));

  // R6: programming begins right after chip select rises
  a_r6_start_on_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));

  // R8: latch is frozen while busy persists
  a_r8_latch_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (wel == $past(wel)));

  // R7: array writes happen only inside the busy window
  a_r7_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R5: page bits hold still while data bytes load
  a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && $past(in_data)) |-> $stable(page));
endmodule

bind spi_eeprom_wr_ctrl spi_ee_wr_chk #(.PG_W(ARRAY_AW - PAGE_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel_q), .mem_we(mem_we),
  .cs_rise(cs_rise), .in_data(in_data), .page(page_q)
);

// File: tb/spi_eeprom_wr_ctrl_tb_top.sv
module spi_eeprom_wr_ctrl_tb_top;
  localparam int AAW  = 11;
  localparam int PAW  = 6;
  localparam int PCYC = 2000;
  localparam int HALF = 6;
  localparam int DEPTH = 1 << AAW;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe;
  logic [AAW-1:0] rd_a = '0;
  logic [7:0] rd_d;

  always #2 clk = ~clk;

  spi_eeprom_wr_ctrl #(.ARRAY_AW(AAW), .PAGE_AW(PAW), .PROG_CYCLES(PCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .so(so), .so_oe(so_oe), .mem_rd_addr(rd_a), .mem_rd_data(rd_d)
  );

  int n_chk = 0, n_err = 0;
  bit mode3 = 1'b0;
  bit oe_hit = 1'b0;
  logic [7:0] mdl [DEPTH];
  bit kn [DEPTH];
  logic [7:0] dq [128];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_begin();
    @(negedge clk);
    sck = mode3;
    ticks(2);
    cs_n = 1'b0;
    oe_hit = 1'b0;
    ticks(HALF);
  endtask

  task automatic cs_finish();
    sck = mode3;
    ticks(HALF);
    cs_n = 1'b1;
    ticks(6);
  endtask

  task automatic xbits(input logic [7:0] b, input int nb, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      sck = 1'b0;
      si = b[i];
      ticks(HALF);
      r[i] = so;
      if (so_oe) oe_hit = 1'b1;
      sck = 1'b1;
      ticks(HALF);
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    xbits(b, 8, r);
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] t;
    cs_begin();
    xfer(8'h05, t);
    xfer(8'h00, s);
    cs_finish();
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] t;
    cs_begin();
    xfer(op, t);
    cs_finish();
  endtask

  task automatic wr_frame(input logic [15:0] a, input int n);
    logic [7:0] t;
    cs_begin();
    xfer(8'h02, t);
    xfer(a[15:8], t);
    xfer(a[7:0], t);
    for (int i = 0; i < n; i++) xfer(dq[i], t);
    cs_finish();
  endtask

  // Page-buffer model: wrap within page, last loaded byte wins
  task automatic model_write(input logic [15:0] a, input int n);
    logic [AAW-1:0] base;
    logic [PAW-1:0] off;
    base = a[AAW-1:0] & ~(AAW'((1 << PAW) - 1));
    off = a[PAW-1:0];
    for (int i = 0; i < n; i++) begin
      mdl[base + AAW'(off)] = dq[i];
      kn[base + AAW'(off)] = 1'b1;
      off = off + 1'b1;
    end
  endtask

  task automatic mem_rd(input logic [AAW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_a = a;
    @(negedge clk);
    d = rd_d;
  endtask

  task automatic wait_ready(input string tag);
    logic [7:0] s;
    s = 8'hFF;
    for (int k = 0; k < 40; k++) begin
      rd_status(s);
      if (!s[0]) break;
    end
    chk(s == 8'h00, tag, s, 8'h00);
  endtask

  task automatic check_page(input logic [15:0] a, input string tag);
    logic [AAW-1:0] base;
    logic [7:0] d;
    base = a[AAW-1:0] & ~(AAW'((1 << PAW) - 1));
    for (int i = 0; i < (1 << PAW); i++) begin
      if (kn[base + AAW'(i)]) begin
        mem_rd(base + AAW'(i), d);
        chk(d == mdl[base + AAW'(i)], tag, d, mdl[base + AAW'(i)]);
      end
    end
  endtask

  initial begin
    logic [7:0] s, s2, d, t;
    int seed_v;
    for (int i = 0; i < DEPTH; i++) kn[i] = 1'b0;
    seed_v = $urandom(32'h5EED_0042);
    ticks(5);
    rst_n = 1'b1;
    ticks(3);

    // R1: reset state
    chk(so_oe == 1'b0, "R1 so_oe after reset", so_oe, 0);
    rd_status(s);
    chk(s == 8'h00, "R1 status after reset", s, 8'h00);

    // R2: latch set / clear
    cmd1(8'h06);
    rd_status(s);
    chk(s == 8'h02, "R2 latch set", s, 8'h02);
    cmd1(8'h04);
    rd_status(s);
    chk(s == 8'h00, "R2 latch clear", s, 8'h00);

    // R4, R7, R8: directed write, busy lockout
    cmd1(8'h06);
    dq[0] = 8'h11; dq[1] = 8'h22; dq[2] = 8'h33;
    wr_frame(16'h0010, 3);
    chk(oe_hit == 1'b0, "R10 so_oe during write", oe_hit, 0);
    model_write(16'h0010, 3);
    rd_status(s);
    chk(s == 8'h03, "R7 busy after commit", s, 8'h03);
    cmd1(8'h04);
    rd_status(s);
    chk(s == 8'h03, "R8 latch-clear ignored while busy", s, 8'h03);
    dq[0] = 8'h99;
    wr_frame(16'h0010, 1);
    wait_ready("R9 ready and latch clear after cycle");
    check_page(16'h0010, "R8 R4 directed page");

    // R3: write without latch
    dq[0] = 8'hFF;
    wr_frame(16'h0010, 1);
    rd_status(s);
    chk(s == 8'h00, "R3 no busy without latch", s, 8'h00);
    mem_rd(AAW'(16'h0010), d);
    chk(d == 8'h11, "R3 array unchanged", d, 8'h11);

    // R4: upper address bits ignored
    cmd1(8'h06);
    dq[0] = 8'h44;
    wr_frame(16'hF812, 1);
    model_write(16'hF812, 1);
    wait_ready("R7 ready after upper-bit write");
    mem_rd(AAW'(16'h0012), d);
    chk(d == 8'h44, "R4 upper bits ignored", d, 8'h44);

    // R5: wrap at page end
    cmd1(8'h06);
    dq[0] = 8'hA0; dq[1] = 8'hA1; dq[2] = 8'hA2; dq[3] = 8'hA3;
    wr_frame(16'h007E, 4);
    model_write(16'h007E, 4);
    wait_ready("R7 ready after wrap write");
    check_page(16'h0040, "R5 wrap within page");

    // R5: overlong load overwrites start of page
    cmd1(8'h06);
    for (int i = 0; i < 66; i++) dq[i] = 8'(i * 3 + 7);
    wr_frame(16'h0080, 66);
    model_write(16'h0080, 66);
    wait_ready("R7 ready after 66-byte write");
    mem_rd(AAW'(16'h0080), d);
    chk(d == 8'(64 * 3 + 7), "R5 last load wins", d, 8'(64 * 3 + 7));
    check_page(16'h0080, "R5 overlong page");

    // R6: aborts
    cmd1(8'h06);
    dq[0] = 8'hC3;
    wr_frame(16'h0100, 1);
    model_write(16'h0100, 1);
    wait_ready("R7 ready before abort tests");
    cmd1(8'h06);
    cs_begin();
    xfer(8'h02, t); xfer(8'h01, t); xfer(8'h00, t); xfer(8'h5A, t);
    xbits(8'hE0, 3, t);
    cs_finish();
    rd_status(s);
    chk(s == 8'h02, "R6 mid-byte abort no busy", s, 8'h02);
    cs_begin();
    xfer(8'h02, t); xfer(8'h01, t); xfer(8'h00, t);
    cs_finish();
    rd_status(s);
    chk(s == 8'h02, "R6 no-data abort no busy", s, 8'h02);
    mem_rd(AAW'(16'h0100), d);
    chk(d == 8'hC3, "R6 array unchanged after abort", d, 8'hC3);
    cmd1(8'h04);

    // R11, R2: mode 3 and repeated status byte
    mode3 = 1'b1;
    cmd1(8'h06);
    cs_begin();
    xfer(8'h05, t); xfer(8'h00, s); xfer(8'h00, s2);
    cs_finish();
    chk(s == 8'h02, "R11 mode3 status", s, 8'h02);
    chk(s2 == 8'h02, "R2 repeated status byte", s2, 8'h02);
    chk(oe_hit == 1'b1, "R10 so_oe during status", oe_hit, 1);
    dq[0] = 8'h5C; dq[1] = 8'hC5; dq[2] = 8'h7E;
    wr_frame(16'h0200, 3);
    model_write(16'h0200, 3);
    wait_ready("R11 mode3 ready");
    check_page(16'h0200, "R11 mode3 write");

    // Random writes, R12 read port via page checks
    for (int it = 0; it < 8; it++) begin
      logic [15:0] a;
      int n;
      mode3 = 1'($urandom % 2);
      a = 16'($urandom);
      n = 1 + int'($urandom % 70);
      for (int i = 0; i < n; i++) dq[i] = 8'($urandom);
      cmd1(8'h06);
      wr_frame(a, n);
      chk(oe_hit == 1'b0, "R10 so_oe random write", oe_hit, 0);
      model_write(a, n);
      wait_ready("R7 random ready");
      check_page(a, "R12 R5 random page");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not complete)");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule